// File: doc/BRIEF.md
# Indirect Extended Register Window

This block is the host-side front end for a bank of extended configuration registers. The bank has no addresses of its own on the host bus. The host reaches it through one host-visible window location, which plays two roles. In address mode a write to the window stores a 5-bit extended register number, a switch flag and a capture-hold control bit. Once the switch flag is set and the block is in the windowed operating mode, the same window location reads and writes the extended register that the stored number selects.

The window goes back to address mode only when the host writes the primary index location. Staying in the data role until that write lets software stream several accesses to one extended register without setting the address again. When the operating mode is not the windowed one, the window behaves as a plain 8-bit register and the switch flag changes nothing. The capture-hold bit is driven on its own output to freeze an adaptive capture state machine outside the block.

Top module: `ext_reg_window`

## Requirements
- R1: After a synchronous reset, the index location (host address 0) and the window location (host address 1) both read 0x00, the block is in address mode and `capture_hold` is 0.
- R2: In address mode a window write stores the extended register number with its low four bits taken from data bits 7..4 and its top bit from data bit 2, the switch flag from data bit 3 and the capture-hold control from data bit 0. A window read returns these fields in the same positions.
- R3: Data bit 1 of the window is reserved. A read of the window in address mode returns 0 in bit 1, whatever was written there.
- R4: With `mode_sel` equal to 3 and the switch flag set, window writes go to the selected extended register and window reads return its contents.
- R5: While the window is in the data role, a window write leaves the stored register number, the switch flag and `capture_hold` unchanged.
- R6: A write to the index location stores its data, which reads back at host address 0, and clears the switch flag. The window then returns to address mode with the register number and capture-hold bit unchanged.
- R7: Extended registers 0 through 17 and 25 each keep their own 8-bit value, with no aliasing between them.
- R8: An extended register number outside 0..17 and 25 has no storage. A write to it changes nothing, and a read of it returns 0x00.
- R9: With `mode_sel` other than 3 the window is an ordinary register. Every write stores its fields, including the switch flag (bit 1 still reads 0), and no write reaches the extended bank.
- R10: `capture_hold` equals the capture-hold bit last stored by an address-mode window write.
- R11: Read data appears on `host_rdata` in the cycle after the clock edge that samples `host_rd` high, and holds its value until the next read.
- R12: A host address other than 0 and 1 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode; value 3 enables the extended window |
| host_addr | input | 2 | Host register address: 0 index, 1 window |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_rdata | output | 8 | Registered read data |
| capture_hold | output | 1 | Stored capture-hold control |

## Verification
The main function is tried with register numbers at both ends of the low run (0 and 17), the lone upper register 25, one register in between (5), and two holes (18 and 24). This separates correct top-bit placement from swapped fields, and real storage from aliasing or phantom registers. Writes in the data role carry patterns that would corrupt the capture-hold bit or the address if they leaked into the control register. The same byte sequences are then replayed in a non-windowed mode, which shows that the switch flag is only stored there and that the extended bank stays untouched. Reserved bit 1 is set in several writes, so a stored reserved bit would show up on readback.

// File: rtl/xwin_pkg.sv
package xwin_pkg;

    parameter int DATA_W      = 8;
    parameter int EXT_AW      = 5;
    parameter int HOST_AW     = 2;
    parameter int MODE_W      = 2;
    parameter int WINDOW_MODE = 3;
    parameter int IDX_LOC     = 0;
    parameter int WIN_LOC     = 1;
    parameter int LOW_LAST    = 17;
    parameter int EXTRA_SLOT  = 25;

    localparam int EXT_SLOTS = 1 << EXT_AW;

    // Window control byte in address mode; the field order is what the host decodes.
    typedef struct packed {
        logic [3:0] num_lo;
        logic       swap;
        logic       num_hi;
        logic       rsvd;
        logic       hold;
    } win_ctl_t;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic [HOST_AW-1:0] addr;
        logic [DATA_W-1:0]  data;
    } host_req_t;

    function automatic logic [EXT_AW-1:0] ctl_target(input win_ctl_t c);
        return {c.num_hi, c.num_lo};
    endfunction

    function automatic logic slot_present(input int unsigned n);
        return (n <= LOW_LAST) || (n == EXTRA_SLOT);
    endfunction

endpackage

// File: rtl/xwin_ctrl.sv
module xwin_ctrl
    import xwin_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int MW = MODE_W,
    parameter int AW = EXT_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  host_req_t     req,
    input  logic [MW-1:0] mode,
    output win_ctl_t      ctl_q,
    output logic [DW-1:0] idx_q,
    output logic          data_mode,
    output logic          ext_wr,
    output logic [AW-1:0] ext_sel
);
    localparam logic [MW-1:0]      WIN_MODE_V = WINDOW_MODE[MW-1:0];
    localparam logic [HOST_AW-1:0] IDX_V      = IDX_LOC[HOST_AW-1:0];
    localparam logic [HOST_AW-1:0] WIN_V      = WIN_LOC[HOST_AW-1:0];

    logic idx_hit;
    logic win_hit;
    win_ctl_t wr_ctl;

    assign idx_hit   = (req.addr == IDX_V);
    assign win_hit   = (req.addr == WIN_V);
    assign data_mode = ctl_q.swap && (mode == WIN_MODE_V);
    assign ext_wr    = req.wr && win_hit && data_mode;
    assign ext_sel   = ctl_target(ctl_q);

    always_comb begin
        wr_ctl      = win_ctl_t'(req.data);
        wr_ctl.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            idx_q <= '0;
        end else if (req.wr && idx_hit) begin
            idx_q      <= req.data;
            ctl_q.swap <= 1'b0;
        end else if (req.wr && win_hit && !data_mode) begin
            ctl_q <= wr_ctl;
        end
    end

    assert_idx_drops_swap_R6: assert property (@(posedge clk) disable iff (rst)
        (req.wr && idx_hit) |=> !ctl_q.swap);

    assert_data_wr_keeps_ctl_R5: assert property (@(posedge clk) disable iff (rst)
        ext_wr |=> $stable(ctl_q));

    assert_plain_mode_stores_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (req.wr && win_hit && mode != WIN_MODE_V) |=> (ctl_q.swap == $past(req.data[3])));

endmodule

// File: rtl/xwin_bank.sv
module xwin_bank
    import xwin_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = EXT_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_val
);
    localparam int SLOTS = 1 << AW;

    logic [DW-1:0] slot_val [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if ((i <= LOW_LAST) || (i == EXTRA_SLOT)) begin : g_real
            logic [DW-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cell_q <= '0;
                end else if (wr_en && (sel == AW'(i))) begin
                    cell_q <= wdata;
                end
            end
            assign slot_val[i] = cell_q;
        end else begin : g_hole
            assign slot_val[i] = '0;
        end
    end

    assign rd_val = slot_val[sel];

endmodule

// File: rtl/xwin_rdport.sv
module xwin_rdport
    import xwin_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = EXT_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd,
    input  logic [HOST_AW-1:0] addr,
    input  logic [DW-1:0]      idx_q,
    input  win_ctl_t           ctl_q,
    input  logic               data_mode,
    input  logic [AW-1:0]      ext_sel,
    input  logic [DW-1:0]      ext_val,
    output logic [DW-1:0]      rd_data
);
    localparam logic [HOST_AW-1:0] IDX_V = IDX_LOC[HOST_AW-1:0];
    localparam logic [HOST_AW-1:0] WIN_V = WIN_LOC[HOST_AW-1:0];

    logic [DW-1:0] rd_next;
    logic          win_rd;

    assign win_rd = (addr == WIN_V);

    always_comb begin
        rd_next = '0;
        if (addr == IDX_V) begin
            rd_next = idx_q;
        end else if (win_rd) begin
            rd_next = data_mode ? ext_val : DW'(ctl_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd) begin
            rd_data <= rd_next;
        end
    end

    assert_rd_holds_R11: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rd_data));

    assert_rsvd_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && win_rd && !data_mode) |=> (rd_data[1] == 1'b0));

    assert_hole_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd && win_rd && data_mode && !slot_present(int'(ext_sel))) |=> (rd_data == '0));

endmodule

// File: rtl/ext_reg_window.sv
module ext_reg_window
    import xwin_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int HAW = HOST_AW,
    parameter int MW  = MODE_W,
    parameter int XAW = EXT_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [MW-1:0]  mode_sel,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    input  logic           host_wr,
    input  logic           host_rd,
    output logic [DW-1:0]  host_rdata,
    output logic           capture_hold
);
    host_req_t      req;
    win_ctl_t       ctl_q;
    logic [DW-1:0]  idx_q;
    logic           data_mode;
    logic           ext_wr;
    logic [XAW-1:0] ext_sel;
    logic [DW-1:0]  ext_val;

    assign req = '{wr: host_wr, rd: host_rd, addr: host_addr, data: host_wdata};

    xwin_ctrl #(.DW(DW), .MW(MW), .AW(XAW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .mode      (mode_sel),
        .ctl_q     (ctl_q),
        .idx_q     (idx_q),
        .data_mode (data_mode),
        .ext_wr    (ext_wr),
        .ext_sel   (ext_sel)
    );

    xwin_bank #(.DW(DW), .AW(XAW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ext_wr),
        .sel    (ext_sel),
        .wdata  (host_wdata),
        .rd_val (ext_val)
    );

    xwin_rdport #(.DW(DW), .AW(XAW)) u_rdport (
        .clk       (clk),
        .rst       (rst),
        .rd        (host_rd),
        .addr      (host_addr),
        .idx_q     (idx_q),
        .ctl_q     (ctl_q),
        .data_mode (data_mode),
        .ext_sel   (ext_sel),
        .ext_val   (ext_val),
        .rd_data   (host_rdata)
    );

    assign capture_hold = ctl_q.hold;

    assert_hold_follows_write_R10: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == HAW'(WIN_LOC) && !data_mode)
            |=> (capture_hold == $past(host_wdata[0])));

endmodule

// File: tb/ext_reg_window_bench.sv
`timescale 1ns/1ps
module ext_reg_window_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'd3;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       capture_hold;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    logic pend  = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    ext_reg_window u_ext_reg_window (
        .clk          (clk),
        .rst          (rst),
        .mode_sel     (mode_sel),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_rdata   (host_rdata),
        .capture_hold (capture_hold)
    );

    // Monitor: a read sampled at a rising edge is compared at the next falling edge.
    always @(posedge clk) pend <= host_rd && !rst;

    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (host_rdata !== e) begin
                misses++;
                $display("FAIL %s: host_rdata=%02h expected=%02h", t, host_rdata, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic chk(input logic [7:0] got, input logic [7:0] e, input string t);
        vectors++;
        if (got !== e) begin
            misses++;
            $display("FAIL %s: actual=%02h expected=%02h", t, got, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        misses++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, 8'h00, "R1 index");
        rd(2'd1, 8'h00, "R1 window");
        chk({7'd0, capture_hold}, 8'h00, "R1 capture_hold");
        rd(2'd2, 8'h00, "R12 unused address");

        // R2/R3/R10 address mode: number 26, hold set, reserved bit written 1
        wr(2'd1, 8'hA7);
        rd(2'd1, 8'hA5, "R2 R3 window fields");
        chk({7'd0, capture_hold}, 8'h01, "R10 hold set");

        // R4 enter data role for register 5, hold clear
        wr(2'd1, 8'h58);
        chk({7'd0, capture_hold}, 8'h00, "R10 hold clear");
        wr(2'd1, 8'h3C);
        rd(2'd1, 8'h3C, "R4 data readback reg5");
        chk({7'd0, capture_hold}, 8'h00, "R5 hold untouched");

        // R6 index write returns to address mode
        wr(2'd0, 8'h17);
        rd(2'd1, 8'h50, "R6 window back to address");
        rd(2'd0, 8'h17, "R6 index readback");

        // R7 distinct registers 17, 25, 0
        wr(2'd1, 8'h1C); wr(2'd1, 8'hE1); wr(2'd0, 8'h00);
        wr(2'd1, 8'h9C); wr(2'd1, 8'h77); wr(2'd0, 8'h00);
        wr(2'd1, 8'h08); wr(2'd1, 8'h42); wr(2'd0, 8'h00);
        wr(2'd1, 8'h58); rd(2'd1, 8'h3C, "R7 reg5");  wr(2'd0, 8'h00);
        wr(2'd1, 8'h1C); rd(2'd1, 8'hE1, "R7 reg17"); wr(2'd0, 8'h00);
        wr(2'd1, 8'h9C); rd(2'd1, 8'h77, "R7 reg25"); wr(2'd0, 8'h00);
        wr(2'd1, 8'h08); rd(2'd1, 8'h42, "R7 reg0");  wr(2'd0, 8'h00);

        // R8 holes 18 and 24
        wr(2'd1, 8'h2C); wr(2'd1, 8'hFF); rd(2'd1, 8'h00, "R8 hole18"); wr(2'd0, 8'h00);
        wr(2'd1, 8'h8C); wr(2'd1, 8'hFF); rd(2'd1, 8'h00, "R8 hole24"); wr(2'd0, 8'h00);
        wr(2'd1, 8'h1C); rd(2'd1, 8'hE1, "R8 reg17 unaliased"); wr(2'd0, 8'h00);
        wr(2'd1, 8'h9C); rd(2'd1, 8'h77, "R8 reg25 unaliased"); wr(2'd0, 8'h00);
        wr(2'd1, 8'h08); rd(2'd1, 8'h42, "R8 reg0 unaliased");  wr(2'd0, 8'h00);

        // R5 data-role write with bit0 clear leaves hold set
        wr(2'd1, 8'h59);
        chk({7'd0, capture_hold}, 8'h01, "R10 hold via select");
        wr(2'd1, 8'hC2);
        chk({7'd0, capture_hold}, 8'h01, "R5 hold kept");
        wr(2'd0, 8'h00);
        rd(2'd1, 8'h51, "R5 R6 control kept");

        // R9 other mode: plain register
        mode_sel = 2'd0;
        wr(2'd1, 8'h5B);
        rd(2'd1, 8'h59, "R9 flag stored plain");
        wr(2'd1, 8'h66);
        rd(2'd1, 8'h64, "R9 plain overwrite");
        chk({7'd0, capture_hold}, 8'h00, "R9 R10 hold from plain write");
        mode_sel = 2'd3;
        wr(2'd1, 8'h58);
        rd(2'd1, 8'hC2, "R9 reg5 untouched");

        // R11 hold without read strobe
        repeat (3) @(negedge clk);
        chk(host_rdata, 8'hC2, "R11 rdata holds");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            misses++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule